// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an EDO DRAM of 1024 rows alive. After reset it holds every strobe inactive for a start-up delay. It then runs a fixed burst of RAS-only initialisation pulses and raises `init_done`. From then on a timer adds one refresh to a backlog every `REFRESH_INTERVAL` clocks. The default is 16 ms spread over 1024 rows, which is about 15.6 us. While the backlog is non-zero the block asks the access controller for the bus through `ref_req`. Each accepted `ref_grant` runs exactly one refresh cycle on strobes that the block drives itself.

A refresh is either CAS-before-RAS or RAS-only, chosen by `use_row_refresh` when the refresh starts. A CAS-before-RAS refresh presents no address. A RAS-only refresh presents the value of an internal row counter, which steps after each such refresh. Outside a refresh the DRAM strobes and address come straight from the access controller. During the start-up delay and the initialisation burst the block owns the strobes.

The state machine has these states:
- `S_PWR_WAIT` is the start-up delay.
- `S_INIT_LOW` and `S_INIT_HIGH` form one initialisation pulse and its recovery.
- `S_IDLE` passes the controller's strobes through.
- `S_CBR_CAS` and `S_CBR_RAS` form a CAS-before-RAS refresh.
- `S_ROR_SETUP` and `S_ROR_RAS` form a RAS-only refresh.
- `S_PRECHARGE` is the recovery time after a refresh.

Its transitions are:
- `S_PWR_WAIT` moves to `S_INIT_LOW` when the delay expires.
- `S_INIT_LOW` moves to `S_INIT_HIGH`.
- `S_INIT_HIGH` moves back to `S_INIT_LOW`, or to `S_IDLE` after the last pulse.
- `S_IDLE` moves to `S_CBR_CAS` or `S_ROR_SETUP` when a grant meets a pending refresh.
- `S_CBR_CAS` moves to `S_CBR_RAS`, and `S_CBR_RAS` moves to `S_PRECHARGE`.
- `S_ROR_SETUP` moves to `S_ROR_RAS`, and `S_ROR_RAS` moves to `S_PRECHARGE`.
- `S_PRECHARGE` moves back to `S_IDLE`.

Top module: `dref_sequencer`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_ucas_n` and `dram_lcas_n` stay high, whatever the controller drives, for exactly `PWRUP_CYCLES` clock edges. The first RAS fall appears after edge `PWRUP_CYCLES`, counting the first edge with `rst_n` high as edge 1.
- R2: The start-up delay is followed by exactly `INIT_PULSES` RAS pulses, with both CAS strobes high. Each pulse is low for `T_RAS` cycles and high for `T_RP` cycles. `init_done` rises after the last pulse.
- R3: `ref_req` is low until `init_done` is high. The first refresh is queued `REFRESH_INTERVAL` cycles after `init_done` rises. While grants are served at once, refresh RAS falls are exactly `REFRESH_INTERVAL` cycles apart.
- R4: The backlog of pending refreshes saturates at `MAX_PENDING`. `ref_urgent` is high exactly when the backlog is full. Draining a full backlog runs no more refreshes than the cap plus any that arrive during the drain.
- R5: A refresh never starts without `ref_grant` high in `S_IDLE`. While a request waits without a grant, the block drives no strobe of its own.
- R6: In `S_IDLE`, `dram_ras_n`, `dram_ucas_n`, `dram_lcas_n` and `dram_addr` equal `ctl_ras_n`, `ctl_ucas_n`, `ctl_lcas_n` and `ctl_addr`.
- R7: A CAS-before-RAS refresh (`use_row_refresh`=0) proceeds as follows:
  - In the first cycle after the granting edge, both CAS strobes are low.
  - RAS falls `T_CSR` cycles after the CAS strobes and stays low for `T_RAS` cycles.
  - All strobes then stay high for `T_RP` cycles.
  - The CAS strobes are low for `T_CSR`+`T_RAS` cycles in total.
- R8: A RAS-only refresh (`use_row_refresh`=1) keeps both CAS strobes high. It drives RAS low for `T_RAS` cycles, with the row counter value on `dram_addr` (row in the low bits, upper bits zero).
- R9: The row counter is 0 after reset. It advances by one after each RAS-only refresh and wraps from 1023 to 0. CAS-before-RAS refreshes and initialisation pulses leave it unchanged.
- R10: `ref_req` goes low in the cycle after a grant is accepted and stays low until the refresh completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_row_refresh | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| ref_grant | input | 1 | Access controller hands the strobes to the block |
| ctl_ras_n | input | 1 | Controller row strobe |
| ctl_ucas_n | input | 1 | Controller upper-byte column strobe |
| ctl_lcas_n | input | 1 | Controller lower-byte column strobe |
| ctl_addr | input | ADDR_W | Controller multiplexed address |
| init_done | output | 1 | Power-up sequence finished |
| ref_req | output | 1 | At least one refresh pending, block idle |
| ref_urgent | output | 1 | Backlog at its cap |
| dram_ras_n | output | 1 | Row strobe to the DRAM |
| dram_ucas_n | output | 1 | Upper column strobe to the DRAM |
| dram_lcas_n | output | 1 | Lower column strobe to the DRAM |
| dram_addr | output | ADDR_W | Address to the DRAM |

## Verification
The assertions assume that the access controller leaves its strobes inactive while the block owns the bus. The bench only moves `ctl_*` during the start-up delay and while a request waits ungranted. The assertions also assume that `use_row_refresh` changes only while no refresh is being granted. The bench sets it at a falling edge with the grant low and the block idle. The timing parameters are assumed to be at least one cycle and the refresh interval longer than one refresh. The bench uses short values (100-cycle delay, 50-cycle interval) that keep every refresh well inside one interval, so the spacing of refreshes served at once can be checked exactly.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_INIT_LOW,
        S_INIT_HIGH,
        S_IDLE,
        S_CBR_CAS,
        S_CBR_RAS,
        S_ROR_SETUP,
        S_ROR_RAS,
        S_PRECHARGE
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_refresh_timer.sv
module dref_refresh_timer #(
    parameter int unsigned INTERVAL    = 3906,
    parameter int unsigned MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic take_i,
    output logic pending_o,
    output logic urgent_o
);
    localparam int unsigned IW = $clog2(INTERVAL);
    localparam int unsigned PW = $clog2(MAX_PENDING + 1);

    logic [IW-1:0] tick_cnt_q;
    logic [PW-1:0] backlog_q;
    logic          tick_c;

    assign tick_c = en_i && (tick_cnt_q == IW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (!en_i || tick_c) begin
            tick_cnt_q <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            backlog_q <= '0;
        end else begin
            unique case ({tick_c, take_i})
                2'b10: if (backlog_q != PW'(MAX_PENDING)) backlog_q <= backlog_q + 1'b1;
                2'b01: backlog_q <= backlog_q - 1'b1;
                default: backlog_q <= backlog_q;
            endcase
        end
    end

    assign pending_o = (backlog_q != '0);
    assign urgent_o  = (backlog_q == PW'(MAX_PENDING));

    // R4: backlog never exceeds its cap
    p_backlog_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_q <= PW'(MAX_PENDING));

    // R4: a refresh is only taken from a non-empty backlog
    p_take_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (backlog_q != '0));

endmodule

// File: rtl/dref_row_counter.sv
module dref_row_counter #(
    parameter int unsigned ROWS = 1024
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv_i,
    output logic [$clog2(ROWS)-1:0]   row_o
);
    localparam int unsigned ROW_W = $clog2(ROWS);

    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (adv_i) begin
            row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
    end

    assign row_o = row_q;

    // R9: top row wraps to zero
    p_row_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && row_q == ROW_W'(ROWS - 1)) |=> (row_q == '0));

    // R9: row holds when not advanced
    p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(row_q));

endmodule

// File: rtl/dref_strobe_fsm.sv
module dref_strobe_fsm
    import dref_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 50000,
    parameter int unsigned INIT_PULSES  = 8,
    parameter int unsigned T_RAS        = 13,
    parameter int unsigned T_RP         = 8,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned ROW_W        = 10,
    parameter int unsigned ADDR_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending_i,
    input  logic              grant_i,
    input  logic              row_mode_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic              own_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              start_o,
    output logic              req_o,
    output logic              row_adv_o,
    output logic              init_done_o
);
    localparam int unsigned LONGEST = max_u(max_u(PWRUP_CYCLES, T_RAS), max_u(T_RP, T_CSR));
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam int unsigned INIT_W  = $clog2(INIT_PULSES + 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [INIT_W-1:0] init_cnt_q;
    logic              init_done_q;
    logic [31:0]       span_c;
    logic              span_end_c;
    logic              grab_c;

    // length of each timed state in cycles
    always_comb begin
        unique case (state_q)
            S_PWR_WAIT:  span_c = PWRUP_CYCLES;
            S_INIT_LOW:  span_c = T_RAS;
            S_INIT_HIGH: span_c = T_RP;
            S_IDLE:      span_c = 32'd1;
            S_CBR_CAS:   span_c = T_CSR;
            S_CBR_RAS:   span_c = T_RAS;
            S_ROR_SETUP: span_c = 32'd1;
            S_ROR_RAS:   span_c = T_RAS;
            S_PRECHARGE: span_c = T_RP;
            default:     span_c = 32'd1;
        endcase
    end

    assign span_end_c = (32'(cnt_q) == span_c - 32'd1);
    assign grab_c     = (state_q == S_IDLE) && pending_i && grant_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PWR_WAIT:  if (span_end_c) state_d = S_INIT_LOW;
            S_INIT_LOW:  if (span_end_c) state_d = S_INIT_HIGH;
            S_INIT_HIGH: if (span_end_c)
                             state_d = (init_cnt_q == INIT_W'(INIT_PULSES - 1)) ? S_IDLE : S_INIT_LOW;
            S_IDLE:      if (grab_c) state_d = row_mode_i ? S_ROR_SETUP : S_CBR_CAS;
            S_CBR_CAS:   if (span_end_c) state_d = S_CBR_RAS;
            S_CBR_RAS:   if (span_end_c) state_d = S_PRECHARGE;
            S_ROR_SETUP: if (span_end_c) state_d = S_ROR_RAS;
            S_ROR_RAS:   if (span_end_c) state_d = S_PRECHARGE;
            S_PRECHARGE: if (span_end_c) state_d = S_IDLE;
            default:     state_d = S_PWR_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_PWR_WAIT;
            cnt_q       <= '0;
            init_cnt_q  <= '0;
            init_done_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == S_INIT_HIGH && span_end_c)
                init_cnt_q <= init_cnt_q + 1'b1;
            if (state_q == S_INIT_HIGH && state_d == S_IDLE)
                init_done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        own_o       = (state_q != S_IDLE);
        ras_n_o     = !(state_q inside {S_INIT_LOW, S_CBR_RAS, S_ROR_RAS});
        cas_n_o     = !(state_q inside {S_CBR_CAS, S_CBR_RAS});
        addr_o      = (state_q inside {S_ROR_SETUP, S_ROR_RAS}) ? ADDR_W'(row_i) : '0;
        start_o     = grab_c;
        req_o       = (state_q == S_IDLE) && pending_i;
        row_adv_o   = (state_q == S_ROR_RAS) && span_end_c;
        init_done_o = init_done_q;
    end

    // R5: idle without a grant stays idle
    p_grant_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !grant_i) |=> (state_q == S_IDLE));

    // R2: init_done never falls once set
    p_init_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |=> init_done_q);

endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer #(
    parameter int unsigned CLK_KHZ           = 250000,
    parameter int unsigned PWRUP_US          = 200,
    parameter int unsigned REFRESH_WINDOW_US = 16000,
    parameter int unsigned ROWS              = 1024,
    parameter int unsigned ADDR_W            = 10,
    parameter int unsigned INIT_PULSES       = 8,
    parameter int unsigned MAX_PENDING       = 8,
    parameter int unsigned T_RAS             = 13,
    parameter int unsigned T_RP              = 8,
    parameter int unsigned T_CSR             = 2,
    parameter int unsigned PWRUP_CYCLES      = (CLK_KHZ / 1000) * PWRUP_US,
    parameter int unsigned REFRESH_INTERVAL  = (CLK_KHZ / 1000) * REFRESH_WINDOW_US / ROWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_row_refresh,
    input  logic              ref_grant,
    input  logic              ctl_ras_n,
    input  logic              ctl_ucas_n,
    input  logic              ctl_lcas_n,
    input  logic [ADDR_W-1:0] ctl_addr,
    output logic              init_done,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic [ADDR_W-1:0] dram_addr
);
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned BOOT_W = $clog2(PWRUP_CYCLES + 1);

    logic              pending, take, row_adv;
    logic              seq_own, seq_ras_n, seq_cas_n;
    logic [ADDR_W-1:0] seq_addr;
    logic [ROW_W-1:0]  row;

    dref_refresh_timer #(
        .INTERVAL    (REFRESH_INTERVAL),
        .MAX_PENDING (MAX_PENDING)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (init_done),
        .take_i    (take),
        .pending_o (pending),
        .urgent_o  (ref_urgent)
    );

    dref_row_counter #(
        .ROWS (ROWS)
    ) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (row_adv),
        .row_o (row)
    );

    dref_strobe_fsm #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .INIT_PULSES  (INIT_PULSES),
        .T_RAS        (T_RAS),
        .T_RP         (T_RP),
        .T_CSR        (T_CSR),
        .ROW_W        (ROW_W),
        .ADDR_W       (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_i   (pending),
        .grant_i     (ref_grant),
        .row_mode_i  (use_row_refresh),
        .row_i       (row),
        .own_o       (seq_own),
        .ras_n_o     (seq_ras_n),
        .cas_n_o     (seq_cas_n),
        .addr_o      (seq_addr),
        .start_o     (take),
        .req_o       (ref_req),
        .row_adv_o   (row_adv),
        .init_done_o (init_done)
    );

    // strobe ownership mux
    assign dram_ras_n  = seq_own ? seq_ras_n : ctl_ras_n;
    assign dram_ucas_n = seq_own ? seq_cas_n : ctl_ucas_n;
    assign dram_lcas_n = seq_own ? seq_cas_n : ctl_lcas_n;
    assign dram_addr   = seq_own ? seq_addr  : ctl_addr;

    // cycles since reset, saturating, for the power-up check
    logic [BOOT_W-1:0] boot_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= '0;
        else if (boot_q != BOOT_W'(PWRUP_CYCLES)) boot_q <= boot_q + 1'b1;
    end

    // R1: strobes quiet through the start-up delay
    p_quiet_powerup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q < BOOT_W'(PWRUP_CYCLES)) |-> (dram_ras_n && dram_ucas_n && dram_lcas_n));

    // R3: no request before initialisation completes
    p_no_early_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    // R5: the block only takes the strobes after a grant
    p_stay_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_own && !ref_grant) |=> !seq_own);

    // R7: during a block-driven RAS fall with CAS low, CAS was already low
    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_own && $past(seq_own) && $fell(dram_ras_n) && !dram_ucas_n)
        |-> (!$past(dram_ucas_n) && !$past(dram_lcas_n)));

    // R10: an accepted grant drops the request
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant) |=> !ref_req);

endmodule

// File: tb/dref_sequencer_tb.sv
`timescale 1ns/1ps
module dref_sequencer_tb;

    localparam int PWR      = 100;
    localparam int INTERVAL = 50;
    localparam int MAXP     = 4;
    localparam int TRAS     = 3;
    localparam int TRP      = 2;
    localparam int TCSR     = 1;
    localparam int NINIT    = 8;
    localparam int NROWS    = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_row_refresh = 1'b0;
    logic       ref_grant = 1'b0;
    logic       ctl_ras_n = 1'b1, ctl_ucas_n = 1'b1, ctl_lcas_n = 1'b1;
    logic [9:0] ctl_addr = '0;
    logic       init_done, ref_req, ref_urgent;
    logic       dram_ras_n, dram_ucas_n, dram_lcas_n;
    logic [9:0] dram_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dref_sequencer #(
        .PWRUP_CYCLES     (PWR),
        .REFRESH_INTERVAL (INTERVAL),
        .MAX_PENDING      (MAXP),
        .T_RAS            (TRAS),
        .T_RP             (TRP),
        .T_CSR            (TCSR),
        .INIT_PULSES      (NINIT)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .use_row_refresh (use_row_refresh),
        .ref_grant       (ref_grant),
        .ctl_ras_n       (ctl_ras_n),
        .ctl_ucas_n      (ctl_ucas_n),
        .ctl_lcas_n      (ctl_lcas_n),
        .ctl_addr        (ctl_addr),
        .init_done       (init_done),
        .ref_req         (ref_req),
        .ref_urgent      (ref_urgent),
        .dram_ras_n      (dram_ras_n),
        .dram_ucas_n     (dram_ucas_n),
        .dram_lcas_n     (dram_lcas_n),
        .dram_addr       (dram_addr)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dram_ras_n && dram_ucas_n && dram_lcas_n, "R1", "strobes high in reset",
            {dram_ras_n, dram_ucas_n, dram_lcas_n}, 7);
        chk(!init_done && !ref_req && !ref_urgent, "R3", "flags low in reset",
            {init_done, ref_req, ref_urgent}, 0);
    endtask

    // R1: controller drives strobes low; outputs must stay high until the delay ends
    task automatic t_powerup();
        int n = 0;
        int cas_bad = 0;
        ctl_ras_n = 1'b0; ctl_ucas_n = 1'b0; ctl_lcas_n = 1'b0;
        rst_n = 1'b1;
        while (n < PWR + 50) begin
            step();
            n++;
            if (!dram_ras_n) break;
            if (!dram_ucas_n || !dram_lcas_n) cas_bad++;
        end
        chk(n == PWR, "R1", "edges before first RAS fall", n, PWR);
        chk(cas_bad == 0, "R1", "CAS activity during delay", cas_bad, 0);
        ctl_ras_n = 1'b1; ctl_ucas_n = 1'b1; ctl_lcas_n = 1'b1;
    endtask

    // R2: count init pulses (first one already low at entry)
    task automatic t_init();
        int pulses = 1;
        int run = 1;
        int width_bad = 0;
        int cas_bad = 0;
        int guard = 0;
        logic prev = 1'b0;
        if (!dram_ucas_n || !dram_lcas_n) cas_bad++;
        while (guard < 500) begin
            step();
            guard++;
            if (init_done) break;
            if (!dram_ras_n && prev) begin pulses++; run = 1; end
            else if (!dram_ras_n) run++;
            if (dram_ras_n && !prev && run != TRAS) width_bad++;
            if (!dram_ucas_n || !dram_lcas_n) cas_bad++;
            prev = dram_ras_n;
        end
        chk(pulses == NINIT, "R2", "init pulse count", pulses, NINIT);
        chk(width_bad == 0, "R2", "init pulse width errors", width_bad, 0);
        chk(cas_bad == 0, "R2", "CAS low during init", cas_bad, 0);
    endtask

    // R3: first request after one interval
    task automatic t_interval();
        int n = 0;
        while (n < INTERVAL + 20) begin
            step();
            n++;
            if (ref_req) break;
        end
        chk(n == INTERVAL, "R3", "cycles from init_done to ref_req", n, INTERVAL);
    endtask

    // R5/R6: pending request without grant leaves controller in charge
    task automatic t_gate();
        int mism = 0;
        int req_lost = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ctl_ras_n  = i[0];
            ctl_ucas_n = i[1];
            ctl_lcas_n = i[2];
            ctl_addr   = 10'(i * 37 + 5);
            #1;
            if (dram_ras_n != ctl_ras_n || dram_ucas_n != ctl_ucas_n ||
                dram_lcas_n != ctl_lcas_n || dram_addr != ctl_addr) mism++;
            if (!ref_req) req_lost++;
        end
        chk(mism == 0, "R6", "pass-through mismatches", mism, 0);
        chk(req_lost == 0, "R5", "refresh started without grant", req_lost, 0);
        @(negedge clk);
        ctl_ras_n = 1'b1; ctl_ucas_n = 1'b1; ctl_lcas_n = 1'b1; ctl_addr = '0;
    endtask

    // R7/R10: one CBR refresh sequence
    task automatic t_cbr();
        int cas_first = -1;
        int ras_first = -1;
        int ras_len = 0;
        int cas_len = 0;
        int both_bad = 0;
        int req_k1 = 0;
        int high_after = 0;
        use_row_refresh = 1'b0;
        ref_grant = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_grant = 1'b0;
        req_k1 = ref_req;
        for (int k = 1; k <= TCSR + TRAS + TRP; k++) begin
            if (k > 1) step();
            if (dram_ucas_n != dram_lcas_n) both_bad++;
            if (!dram_ucas_n) begin cas_len++; if (cas_first < 0) cas_first = k; end
            if (!dram_ras_n)  begin ras_len++; if (ras_first < 0) ras_first = k; end
            if (k > TCSR + TRAS && dram_ras_n && dram_ucas_n) high_after++;
        end
        chk(cas_first == 1, "R7", "first CAS-low cycle", cas_first, 1);
        chk(ras_first == 1 + TCSR, "R7", "first RAS-low cycle", ras_first, 1 + TCSR);
        chk(ras_len == TRAS, "R7", "RAS low cycles", ras_len, TRAS);
        chk(cas_len == TCSR + TRAS, "R7", "CAS low cycles", cas_len, TCSR + TRAS);
        chk(both_bad == 0, "R7", "CAS strobes differ", both_bad, 0);
        chk(high_after == TRP, "R7", "precharge cycles", high_after, TRP);
        chk(req_k1 == 0, "R10", "ref_req after grant", req_k1, 0);
    endtask

    // R4: backlog saturation and drain
    task automatic t_backlog();
        int falls = 0;
        logic prev;
        repeat ((MAXP + 2) * INTERVAL) step();
        chk(ref_urgent == 1'b1, "R4", "urgent at full backlog", ref_urgent, 1);
        chk(ref_req == 1'b1, "R4", "request at full backlog", ref_req, 1);
        ref_grant = 1'b1;
        prev = dram_ucas_n;
        repeat (MAXP * (TCSR + TRAS + TRP + 1) + 5) begin
            step();
            if (!dram_ucas_n && prev) falls++;
            prev = dram_ucas_n;
        end
        ref_grant = 1'b0;
        chk(falls >= MAXP && falls <= MAXP + 1, "R4", "refreshes drained", falls, MAXP);
        chk(ref_urgent == 1'b0, "R4", "urgent after drain", ref_urgent, 0);
        repeat (12) step();
    endtask

    // R8/R9/R3: RAS-only refreshes through a full row wrap
    task automatic t_ror();
        int falls = 0;
        int cyc = 0;
        int last_fall = 0;
        int run = 0;
        int row_bad = 0;
        int first_bad_row = -1;
        int first_bad_exp = -1;
        int gap_bad = 0;
        int cas_bad = 0;
        int width_bad = 0;
        int wrap_row = -1;
        int row0 = -1;
        logic prev;
        use_row_refresh = 1'b1;
        ref_grant = 1'b1;
        prev = dram_ras_n;
        while (falls < NROWS + 2 && cyc < 60000) begin
            step();
            cyc++;
            if (!dram_ras_n && (!dram_ucas_n || !dram_lcas_n)) cas_bad++;
            if (!dram_ras_n && prev) begin
                if (falls == 0) row0 = int'(dram_addr);
                if (falls == NROWS) wrap_row = int'(dram_addr);
                if (int'(dram_addr) != falls % NROWS) begin
                    row_bad++;
                    if (first_bad_row < 0) begin
                        first_bad_row = int'(dram_addr);
                        first_bad_exp = falls % NROWS;
                    end
                end
                if (falls >= 2 && (cyc - last_fall) != INTERVAL) gap_bad++;
                last_fall = cyc;
                falls++;
                run = 1;
            end else if (!dram_ras_n) begin
                run++;
            end
            if (dram_ras_n && !prev && run != TRAS) width_bad++;
            prev = dram_ras_n;
        end
        ref_grant = 1'b0;
        chk(falls == NROWS + 2, "R8", "RAS-only refreshes seen", falls, NROWS + 2);
        chk(row0 == 0, "R9", "first row after reset", row0, 0);
        chk(row_bad == 0, "R9", "row sequence (first wrong row)", first_bad_row, first_bad_exp);
        chk(wrap_row == 0, "R9", "row after 1023", wrap_row, 0);
        chk(cas_bad == 0, "R8", "CAS low during RAS-only", cas_bad, 0);
        chk(width_bad == 0, "R8", "RAS-only width errors", width_bad, 0);
        chk(gap_bad == 0, "R3", "refresh spacing errors", gap_bad, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_init();
        t_interval();
        t_gate();
        t_cbr();
        t_backlog();
        t_ror();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule